// File: doc/BRIEF.md
# Clause 45 MDIO Management Master

This block is a memory-mapped MDIO master for extended (Clause 45) PHY management. Software writes a 16-bit PHY register number into an address register. It then writes a command word that holds the port address, the device address, a 3-bit opcode and, for writes, the data. That command write starts the transaction. The block then runs two Clause 45 frames back to back on the management pins with no further software action. The first is an address frame that carries the stored register number. The second is a write frame or a read frame aimed at the same port and device.

The block generates MDC from the system clock. MDC runs only while a transaction is in progress. The block drives MDIO through a separate output-enable, so the pad can be shared with the PHY. Software polls the busy flag in the command word. After a read it checks the read-valid flag and takes the returned data from the low 16 bits of the same word.

Top module: `mdio45_master`

## Requirements
- R1: After reset, both registers read as zero, busy and read-valid are clear, `mdc` is low and `mdio_oe` is low.
- R2: The register-address register sits at offset 0x8. It keeps bits 15:0 of a write, and reading it returns them in bits 15:0 with zeros above. The command word sits at offset 0x0 and reads back as: data in 15:0, port address in 20:16, device address in 25:21, opcode in 28:26, read-valid in bit 29, busy in bit 30, and 0 in bit 31.
- R3: A command-word write with opcode 5 (write) or 7 (read) while idle starts a transaction, and busy reads as 1 from the next cycle. A command-word write with any other opcode is ignored: busy stays clear and the command word keeps its old contents.
- R4: While busy is set, writes to either register are ignored.
- R5: The first frame is sent MSB first: 32 ones, start bits 00, operation bits 00, the 5-bit port address, the 5-bit device address, turnaround bits 10, and then the 16-bit register address.
- R6: For opcode 5, the second frame uses operation bits 01, the same port and device addresses, turnaround bits 10, and the 16 data bits of the command word.
- R7: For opcode 7, the second frame uses operation bits 11. The master releases `mdio_oe` from the first turnaround bit until the frame ends, and it samples the 16 data bits on rising MDC edges.
- R8: When a read ends, read-valid is set only if `mdio_in` was 0 on the second turnaround bit. The sampled 16 bits then appear in bits 15:0 of the command word. Read-valid is cleared whenever a new command is accepted, and it stays 0 after a write.
- R9: Busy stays set across both frames and clears after the last bit of the second frame, which is exactly 256·MDC_HALF clock cycles after it was set.
- R10: MDC is high for MDC_HALF clocks and low for MDC_HALF clocks, and it stays low while the block is idle. The master changes `mdio_out` only while MDC is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_ADDR_W | Byte offset for a write or a read |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for the register at `reg_addr` |
| mdc | output | 1 | Management clock |
| mdio_out | output | 1 | Management data driven by the master |
| mdio_oe | output | 1 | Output enable for `mdio_out` |
| mdio_in | input | 1 | Management data as seen on the line |

## Verification
The checker watches several rules on every cycle. MDC and the output enable stay quiet while the block is idle. MDC rises only during a transaction. Read-valid is clear whenever a command starts. Read-valid can rise only at the moment busy falls, and busy can fall only after the data frame. Other behaviour can only be shown by the bench's scenarios against a PHY model. That covers the exact bit content of both frames, release of the line and sampling during the read turnaround, the acknowledged and unacknowledged read outcomes, the length of a transaction, and the rejection of illegal opcodes and of writes made while busy.

// File: rtl/mdio45_pkg.sv
package mdio45_pkg;

    // Frame geometry (bit index 0 is the first bit on the wire)
    localparam int FRAME_LEN  = 64;
    localparam int IDX_W      = $clog2(FRAME_LEN);
    localparam int TA_FIRST   = 46;
    localparam int TA_SECOND  = 47;
    localparam int DATA_FIRST = 48;

    // Command word layout
    localparam int REG_W       = 32;
    localparam int F_PRT_LSB   = 16;
    localparam int F_DEV_LSB   = 21;
    localparam int F_OPC_LSB   = 26;

    localparam logic [2:0] OPC_WRITE = 3'd5;
    localparam logic [2:0] OPC_READ  = 3'd7;

    localparam logic [1:0] START_EXT = 2'b00;
    localparam logic [1:0] FOP_ADDR  = 2'b00;
    localparam logic [1:0] FOP_WRITE = 2'b01;
    localparam logic [1:0] FOP_READ  = 2'b11;
    localparam logic [1:0] TA_DRIVE  = 2'b10;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    function automatic logic [FRAME_LEN-1:0] build_frame(
        input logic [1:0]  fop,
        input logic [4:0]  prt,
        input logic [4:0]  dev,
        input logic [15:0] payload
    );
        return {{32{1'b1}}, START_EXT, fop, prt, dev, TA_DRIVE, payload};
    endfunction

endpackage

// File: rtl/mdio45_clkgen.sv
module mdio45_clkgen #(
    parameter int HALF = 25
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic rise,
    output logic fall
);
    localparam int CW = (HALF > 2) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          mdc;
    } gen_t;

    gen_t gen_d, gen_q;
    logic wrap;

    assign wrap = (gen_q.cnt == CW'(HALF - 1));

    always_comb begin
        gen_d = gen_q;
        if (!run) begin
            gen_d = '0;
        end else if (wrap) begin
            gen_d.cnt = '0;
            gen_d.mdc = ~gen_q.mdc;
        end else begin
            gen_d.cnt = gen_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) gen_q <= '0;
        else        gen_q <= gen_d;
    end

    assign mdc  = gen_q.mdc;
    assign rise = run && wrap && !gen_q.mdc;
    assign fall = run && wrap &&  gen_q.mdc;

endmodule

// File: rtl/mdio45_frame.sv
module mdio45_frame
    import mdio45_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic                 is_read,
    input  logic [FRAME_LEN-1:0] frame,
    input  logic                 rise,
    input  logic                 fall,
    input  logic                 mdio_in,
    output logic                 mdio_out,
    output logic                 mdio_oe,
    output logic                 done,
    output logic                 ta_ok,
    output logic [15:0]          rd_data
);
    typedef struct packed {
        logic                 active;
        logic                 rd;
        logic [IDX_W-1:0]     idx;
        logic [FRAME_LEN-1:0] sh;
        logic                 ta_ok;
        logic [15:0]          cap;
    } eng_t;

    eng_t eng_d, eng_q;
    logic last_bit;

    assign last_bit = (eng_q.idx == IDX_W'(FRAME_LEN - 1));

    always_comb begin
        eng_d = eng_q;
        done  = 1'b0;
        if (load) begin
            eng_d.active = 1'b1;
            eng_d.rd     = is_read;
            eng_d.idx    = '0;
            eng_d.sh     = frame;
            eng_d.ta_ok  = 1'b0;
            eng_d.cap    = '0;
        end else if (eng_q.active) begin
            if (rise) begin
                if (eng_q.idx == IDX_W'(TA_SECOND))
                    eng_d.ta_ok = ~mdio_in;
                if (eng_q.idx >= IDX_W'(DATA_FIRST))
                    eng_d.cap = {eng_q.cap[14:0], mdio_in};
            end
            if (fall) begin
                if (last_bit) begin
                    eng_d.active = 1'b0;
                    done         = 1'b1;
                end else begin
                    eng_d.idx = eng_q.idx + 1'b1;
                    eng_d.sh  = {eng_q.sh[FRAME_LEN-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) eng_q <= '0;
        else        eng_q <= eng_d;
    end

    assign mdio_out = eng_q.active & eng_q.sh[FRAME_LEN-1];
    assign mdio_oe  = eng_q.active & ~(eng_q.rd & (eng_q.idx >= IDX_W'(TA_FIRST)));
    assign ta_ok    = eng_q.ta_ok;
    assign rd_data  = eng_q.cap;

endmodule

// File: rtl/mdio45_master.sv
module mdio45_master
    import mdio45_pkg::*;
#(
    parameter int                    MDC_HALF   = 25,
    parameter int                    REG_ADDR_W = 4,
    parameter logic [REG_ADDR_W-1:0] MGMT_OFS   = REG_ADDR_W'(0),
    parameter logic [REG_ADDR_W-1:0] ADDR_OFS   = REG_ADDR_W'(8)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  reg_wr,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]      reg_wdata,
    output logic [REG_W-1:0]      reg_rdata,
    output logic                  mdc,
    output logic                  mdio_out,
    output logic                  mdio_oe,
    input  logic                  mdio_in
);
    typedef struct packed {
        logic        busy;
        logic        rvalid;
        phase_e      phase;
        logic        launch;
        logic [15:0] addr;
        logic [15:0] data;
        logic [4:0]  prt;
        logic [4:0]  dev;
        logic [2:0]  opc;
    } ctl_t;

    ctl_t st_d, st_q;

    logic                 mgmt_wr, addr_wr, cmd_ok;
    logic [2:0]           wr_opc;
    logic                 tick_rise, tick_fall;
    logic                 frm_read, frm_done, frm_ta_ok;
    logic [15:0]          frm_rdata;
    logic [1:0]           frm_op;
    logic [FRAME_LEN-1:0] frm_bits;

    assign mgmt_wr = reg_wr && (reg_addr == MGMT_OFS);
    assign addr_wr = reg_wr && (reg_addr == ADDR_OFS);
    assign wr_opc  = reg_wdata[F_OPC_LSB +: 3];
    assign cmd_ok  = (wr_opc == OPC_WRITE) || (wr_opc == OPC_READ);

    always_comb begin
        st_d        = st_q;
        st_d.launch = 1'b0;
        case (st_q.phase)
            PH_IDLE: begin
                if (addr_wr)
                    st_d.addr = reg_wdata[15:0];
                if (mgmt_wr && cmd_ok) begin
                    st_d.busy   = 1'b1;
                    st_d.rvalid = 1'b0;
                    st_d.phase  = PH_ADDR;
                    st_d.launch = 1'b1;
                    st_d.opc    = wr_opc;
                    st_d.dev    = reg_wdata[F_DEV_LSB +: 5];
                    st_d.prt    = reg_wdata[F_PRT_LSB +: 5];
                    st_d.data   = reg_wdata[15:0];
                end
            end
            PH_ADDR: begin
                if (frm_done) begin
                    st_d.phase  = PH_DATA;
                    st_d.launch = 1'b1;
                end
            end
            PH_DATA: begin
                if (frm_done) begin
                    st_d.phase = PH_IDLE;
                    st_d.busy  = 1'b0;
                    if (st_q.opc == OPC_READ) begin
                        st_d.rvalid = frm_ta_ok;
                        st_d.data   = frm_rdata;
                    end
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Frame selection for the engine
    assign frm_read = (st_q.phase == PH_DATA) && (st_q.opc == OPC_READ);
    assign frm_op   = (st_q.phase == PH_ADDR) ? FOP_ADDR :
                      (st_q.opc == OPC_READ)  ? FOP_READ : FOP_WRITE;
    assign frm_bits = build_frame(frm_op, st_q.prt, st_q.dev,
                                  (st_q.phase == PH_ADDR) ? st_q.addr : st_q.data);

    mdio45_clkgen #(
        .HALF (MDC_HALF)
    ) u_clkgen (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (st_q.busy),
        .mdc   (mdc),
        .rise  (tick_rise),
        .fall  (tick_fall)
    );

    mdio45_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (st_q.launch),
        .is_read  (frm_read),
        .frame    (frm_bits),
        .rise     (tick_rise),
        .fall     (tick_fall),
        .mdio_in  (mdio_in),
        .mdio_out (mdio_out),
        .mdio_oe  (mdio_oe),
        .done     (frm_done),
        .ta_ok    (frm_ta_ok),
        .rd_data  (frm_rdata)
    );

    // Register readback
    always_comb begin
        reg_rdata = '0;
        if (reg_addr == MGMT_OFS)
            reg_rdata = {1'b0, st_q.busy, st_q.rvalid, st_q.opc,
                         st_q.dev, st_q.prt, st_q.data};
        else if (reg_addr == ADDR_OFS)
            reg_rdata = {16'h0000, st_q.addr};
    end

endmodule

// File: rtl/mdio45_master_chk.sv
module mdio45_master_chk
    import mdio45_pkg::*;
(
    input logic   clk,
    input logic   rst_n,
    input logic   busy,
    input logic   rvalid,
    input phase_e phase,
    input logic   mdc,
    input logic   mdio_oe
);
    // R10
    idle_line_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mdc && !mdio_oe));

    // R10
    mdc_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> busy);

    // R8
    rvalid_clear_on_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> !rvalid);

    // R8
    rvalid_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rvalid) |-> $fell(busy));

    // R9
    busy_ends_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(phase) == PH_DATA));

endmodule

bind mdio45_master mdio45_master_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (st_q.busy),
    .rvalid  (st_q.rvalid),
    .phase   (st_q.phase),
    .mdc     (mdc),
    .mdio_oe (mdio_oe)
);

// File: tb/test_mdio45_master.sv
module test_mdio45_master;

    localparam int HALF = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [3:0]  reg_addr = 4'h0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_out, mdio_oe;
    logic        mdio_line;

    logic        phy_en = 1'b0, phy_bit = 1'b1, phy_ack = 1'b1;
    logic [15:0] phy_data = 16'h0000;

    always #2 clk = ~clk;

    assign mdio_line = mdio_oe ? mdio_out : (phy_en ? phy_bit : 1'b1);

    mdio45_master #(.MDC_HALF(HALF)) i_mdio45_master (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .mdc       (mdc),
        .mdio_out  (mdio_out),
        .mdio_oe   (mdio_oe),
        .mdio_in   (mdio_line)
    );

    int checks = 0;
    int fails  = 0;
    bit done_flag = 1'b0;

    typedef struct {
        logic [63:0] bits;
        string       tag;
    } exp_t;
    exp_t expq[$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk(input logic [1:0] op, input logic [4:0] prt,
                                       input logic [4:0] dev, input logic [1:0] ta,
                                       input logic [15:0] d);
        return {32'hFFFF_FFFF, 2'b00, op, prt, dev, ta, d};
    endfunction

    function automatic logic [31:0] cmd(input logic [2:0] op, input logic [4:0] prt,
                                        input logic [4:0] dev, input logic [15:0] d);
        return {3'b000, op, dev, prt, d};
    endfunction

    // Scoreboard monitor and PHY model
    int   pcnt = 0;
    logic fbits [64];

    always @(posedge mdc) begin
        int j;
        logic [63:0] got;
        exp_t e;
        j = pcnt % 64;
        fbits[j] = mdio_line;
        pcnt++;
        if (j == 63) begin
            for (int k = 0; k < 64; k++) got[63-k] = fbits[k];
            if (expq.size() == 0) begin
                check(1'b0, "R5", "unexpected frame", got, 64'h0);
            end else begin
                e = expq.pop_front();
                check(got === e.bits, e.tag, "frame bits", got, e.bits);
            end
        end
    end

    always @(negedge mdc) begin
        int j;
        logic rd;
        j  = pcnt % 64;
        rd = fbits[34] && fbits[35];
        if (j < 47 || !rd) begin
            phy_en = 1'b0;
        end else if (j == 47) begin
            phy_en  = phy_ack;
            phy_bit = 1'b0;
        end else begin
            phy_en  = phy_ack;
            phy_bit = phy_data[63-j];
        end
    end

    // MDC width and line stability monitor (R10)
    int   hi_len = 0;
    int   mdc_bad = 0;
    logic prev_mdc = 1'b0;
    logic prev_line = 1'b1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mdc) begin
                hi_len++;
                if (prev_mdc && (mdio_line !== prev_line)) mdc_bad++;
            end else if (prev_mdc) begin
                if (hi_len != HALF) mdc_bad++;
                hi_len = 0;
            end
            prev_mdc  = mdc;
            prev_line = mdio_line;
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_wr    = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        reg_addr = 4'h0;
        forever begin
            #1;
            if (!reg_rdata[30]) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic push(input logic [63:0] b, input string tag);
        exp_t e;
        e.bits = b;
        e.tag  = tag;
        expq.push_back(e);
    endtask

    function automatic void summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int n;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        reg_read(4'h0, rd);
        check(rd == 32'h0, "R1", "command word after reset", rd, 0);
        reg_read(4'h8, rd);
        check(rd == 32'h0, "R1", "address reg after reset", rd, 0);
        check(!mdc && !mdio_oe, "R1", "mdc/oe after reset", {mdc, mdio_oe}, 0);

        // R2: address register keeps 16 bits
        reg_write(4'h8, 32'h1234_ABCD);
        reg_read(4'h8, rd);
        check(rd == 32'h0000_ABCD, "R2", "address readback", rd, 32'h0000_ABCD);

        // R3: illegal opcode ignored
        reg_write(4'h0, cmd(3'd3, 5'h02, 5'h04, 16'h1357));
        reg_read(4'h0, rd);
        check(rd == 32'h0, "R3", "illegal opcode ignored", rd, 0);

        // Write transaction (R5, R6) with writes while busy (R4)
        push(mk(2'b00, 5'h05, 5'h01, 2'b10, 16'hABCD), "R5");
        push(mk(2'b01, 5'h05, 5'h01, 2'b10, 16'hBEEF), "R6");
        reg_write(4'h0, cmd(3'd5, 5'h05, 5'h01, 16'hBEEF));
        reg_read(4'h0, rd);
        check(rd[30] == 1'b1, "R3", "busy after write command", rd, 32'h4000_0000);
        reg_write(4'h8, 32'h0000_1111);
        reg_write(4'h0, cmd(3'd7, 5'h1F, 5'h1F, 16'h2222));
        reg_read(4'h8, rd);
        check(rd == 32'h0000_ABCD, "R4", "address write ignored while busy", rd, 32'h0000_ABCD);
        wait_idle(n);
        reg_read(4'h0, rd);
        check(rd == cmd(3'd5, 5'h05, 5'h01, 16'hBEEF), "R4", "command write ignored while busy",
              rd, cmd(3'd5, 5'h05, 5'h01, 16'hBEEF));
        check(rd[29] == 1'b0, "R8", "no read-valid after write", rd, 0);

        // Acknowledged read (R7, R8, R9)
        reg_write(4'h8, 32'h0000_0042);
        phy_ack  = 1'b1;
        phy_data = 16'h5A3C;
        push(mk(2'b00, 5'h1F, 5'h1E, 2'b10, 16'h0042), "R5");
        push(mk(2'b11, 5'h1F, 5'h1E, 2'b10, 16'h5A3C), "R7");
        reg_write(4'h0, cmd(3'd7, 5'h1F, 5'h1E, 16'h0000));
        wait_idle(n);
        check(n == 256 * HALF, "R9", "busy duration in clocks", n, 256 * HALF);
        reg_read(4'h0, rd);
        check(rd == (32'h2000_0000 | cmd(3'd7, 5'h1F, 5'h1E, 16'h5A3C)), "R8",
              "acknowledged read result", rd, 32'h2000_0000 | cmd(3'd7, 5'h1F, 5'h1E, 16'h5A3C));

        // Unacknowledged read, boundary fields (R7, R8)
        reg_write(4'h8, 32'h0000_FFFF);
        phy_ack = 1'b0;
        push(mk(2'b00, 5'h00, 5'h00, 2'b10, 16'hFFFF), "R5");
        push(mk(2'b11, 5'h00, 5'h00, 2'b11, 16'hFFFF), "R7");
        reg_write(4'h0, cmd(3'd7, 5'h00, 5'h00, 16'h0000));
        wait_idle(n);
        reg_read(4'h0, rd);
        check(rd == cmd(3'd7, 5'h00, 5'h00, 16'hFFFF), "R8", "unacknowledged read result",
              rd, cmd(3'd7, 5'h00, 5'h00, 16'hFFFF));

        // Read-valid cleared by a new command (R8)
        reg_write(4'h8, 32'h0000_8001);
        phy_ack  = 1'b1;
        phy_data = 16'h0001;
        push(mk(2'b00, 5'h10, 5'h03, 2'b10, 16'h8001), "R5");
        push(mk(2'b11, 5'h10, 5'h03, 2'b10, 16'h0001), "R7");
        reg_write(4'h0, cmd(3'd7, 5'h10, 5'h03, 16'h0000));
        wait_idle(n);
        reg_read(4'h0, rd);
        check(rd[29] == 1'b1 && rd[15:0] == 16'h0001, "R8", "second acknowledged read",
              rd, 32'h2000_0001);
        push(mk(2'b00, 5'h0A, 5'h15, 2'b10, 16'h8001), "R5");
        push(mk(2'b01, 5'h0A, 5'h15, 2'b10, 16'h0000), "R6");
        reg_write(4'h0, cmd(3'd5, 5'h0A, 5'h15, 16'h0000));
        reg_read(4'h0, rd);
        check(rd[30:29] == 2'b10, "R8", "read-valid cleared at new command", rd[30:29], 2'b10);
        wait_idle(n);

        repeat (4) @(negedge clk);
        check(expq.size() == 0, "R5", "all expected frames seen", expq.size(), 0);
        check(mdc_bad == 0, "R10", "mdc width and line stability", mdc_bad, 0);
        check(!mdc && !mdio_oe, "R10", "mdc/oe quiet when idle", {mdc, mdio_oe}, 0);

        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule